// File: doc/BRIEF.md
# Keyboard Serial Frame Receiver

This block listens to the two open lines of a keyboard port, a clock and a data line that the keyboard drives, and turns what it hears into key events in the system clock domain. Both lines idle high. While it sends, the keyboard toggles its clock at a rate of about 10 to 16 kHz. It changes data while its clock is high, and the receiver takes each bit when the clock falls. The block brings both lines through a chain of flops, finds the falling clock edges, collects eleven-bit frames and checks each frame for sound framing and parity.

A key press arrives as a single scan code byte. A key release arrives as the prefix byte 0xF0 followed by the scan code. The block does not pass the prefix through. It remembers the prefix and reports the next good byte with a release flag. A frame with a framing or parity fault raises a one-cycle error pulse and is dropped, and any remembered prefix is dropped with it. If the keyboard clock stops partway through a frame for longer than a set number of system cycles, the partial frame is thrown away so that the next frame is received from its first bit.

Top module: `kbd_frame_rx`

## Requirements
- R1: After reset, `key_valid_o` and `frame_err_o` are 0, `key_code_o` is 0x00 and `key_release_o` is 0.
- R2: A frame is 11 bits, each taken on a falling edge of `kbd_clk_i`: bit 0 is a start bit of 0, bits 1 to 8 are the data byte least significant bit first, bit 9 is a parity bit that makes the count of ones over data and parity odd, and bit 10 is a stop bit of 1. A good frame whose byte is not 0xF0 gives exactly one one-cycle pulse on `key_valid_o`, and `key_code_o` carries the byte during that pulse.
- R3: A good byte that does not follow a pending 0xF0 prefix is reported with `key_release_o` = 0.
- R4: A good frame with byte 0xF0 gives no pulse on either output. The next good byte is reported with `key_release_o` = 1, and the byte reported after that has `key_release_o` = 0 again.
- R5: A frame whose parity bit makes the count of ones even gives one one-cycle pulse on `frame_err_o` and no pulse on `key_valid_o`.
- R6: A frame whose start bit is 1 or whose stop bit is 0 gives one one-cycle pulse on `frame_err_o` and no pulse on `key_valid_o`.
- R7: A faulty frame clears a pending 0xF0 prefix, so the next good byte is reported with `key_release_o` = 0.
- R8: If `kbd_clk_i` has no falling edge for more than `IDLE_LIMIT` system cycles while a frame is incomplete, the partial frame is dropped without any pulse, and the next complete frame is received correctly.
- R9: `key_valid_o` and `frame_err_o` are never high in the same cycle, and each pulse lasts exactly one cycle.
- R10: `key_code_o` and `key_release_o` keep their values between pulses of `key_valid_o`, including across a 0xF0 prefix frame and across a faulty frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kbd_clk_i | input | 1 | Clock line driven by the keyboard, asynchronous |
| kbd_data_i | input | 1 | Data line driven by the keyboard, asynchronous |
| key_code_o | output | 8 | Scan code of the last reported key event |
| key_release_o | output | 1 | 1 when the last reported event was a release |
| key_valid_o | output | 1 | One-cycle pulse when a key event is reported |
| frame_err_o | output | 1 | One-cycle pulse when a frame fails its checks |

## Verification
The hardest state to reach from the ports is a frame cut off partway through. The stimulus has to stop the keyboard clock after a few bits, hold it idle past the limit, and then show that a later complete frame is received bit-aligned, with no pulse on either output in between. The bench does this with a four-bit fragment followed by a full frame. It also builds faulty frames that arrive while a release prefix is pending, so that dropping the prefix can be seen in the release flag of the following good byte. Around these cases it sweeps every byte value as a press and a spread of byte values as releases.

// File: rtl/kbd_rx_pkg.sv
package kbd_rx_pkg;
  localparam int FRAME_BITS = 11;
  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam logic [7:0] BREAK_PREFIX = 8'hF0;

  // Result of one completed frame, valid for one cycle when done is set.
  typedef struct packed {
    logic       done;
    logic       ok;
    logic [7:0] data;
  } frame_result_t;
endpackage

// File: rtl/kbd_line_sync.sv
module kbd_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kclk_async_i,
  input  logic kdat_async_i,
  output logic kdat_o,
  output logic kclk_fall_o
);
  localparam int LINES = 2;

  logic [LINES-1:0] stage_q [STAGES];
  logic             kclk_prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '1;
          else        stage_q[s] <= {kdat_async_i, kclk_async_i};
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '1;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) kclk_prev_q <= 1'b1;
    else        kclk_prev_q <= stage_q[STAGES-1][0];
  end

  assign kdat_o      = stage_q[STAGES-1][1];
  assign kclk_fall_o = kclk_prev_q & ~stage_q[STAGES-1][0];

  // A detected falling edge cannot repeat in the next cycle.
  assert_fall_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    kclk_fall_o |=> !kclk_fall_o);
endmodule

// File: rtl/kbd_frame_fsm.sv
module kbd_frame_fsm
  import kbd_rx_pkg::*;
#(
  parameter int IDLE_LIMIT = 200000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          kdat_i,
  input  logic          kclk_fall_i,
  output frame_result_t result_o
);
  localparam int IDLE_W = $clog2(IDLE_LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);
  localparam logic [IDLE_W-1:0] IDLE_MAX = IDLE_W'(IDLE_LIMIT);

  logic [CNT_W-1:0]      bit_cnt_q, bit_cnt_d;
  logic [FRAME_BITS-2:0] shift_q, shift_d;
  logic [IDLE_W-1:0]     idle_q, idle_d;
  frame_result_t         res_q, res_d;

  logic [FRAME_BITS-1:0] frame_w;
  logic                  start_ok, stop_ok, parity_ok;

  assign frame_w   = {kdat_i, shift_q};
  assign start_ok  = ~frame_w[0];
  assign stop_ok   = frame_w[FRAME_BITS-1];
  assign parity_ok = ^frame_w[9:1];

  always_comb begin
    bit_cnt_d = bit_cnt_q;
    shift_d   = shift_q;
    idle_d    = idle_q;
    res_d     = '{done: 1'b0, ok: res_q.ok, data: res_q.data};

    if (kclk_fall_i) begin
      idle_d = '0;
      if (bit_cnt_q == LAST_BIT) begin
        bit_cnt_d  = '0;
        res_d.done = 1'b1;
        res_d.ok   = start_ok & stop_ok & parity_ok;
        res_d.data = frame_w[8:1];
      end else begin
        bit_cnt_d = bit_cnt_q + CNT_W'(1);
        shift_d   = {kdat_i, shift_q[FRAME_BITS-2:1]};
      end
    end else if (bit_cnt_q == '0) begin
      idle_d = '0;
    end else if (idle_q == IDLE_MAX) begin
      bit_cnt_d = '0;
      idle_d    = '0;
    end else begin
      idle_d = idle_q + IDLE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt_q <= '0;
      shift_q   <= '0;
      idle_q    <= '0;
      res_q     <= '0;
    end else begin
      bit_cnt_q <= bit_cnt_d;
      shift_q   <= shift_d;
      idle_q    <= idle_d;
      res_q     <= res_d;
    end
  end

  assign result_o = res_q;

  assert_bitcnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt_q <= LAST_BIT);
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_q.done |=> !res_q.done);
  assert_idle_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt_q != '0 && idle_q == IDLE_MAX && !kclk_fall_i) |=> (bit_cnt_q == '0 && !res_q.done));
  assert_idle_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    idle_q <= IDLE_MAX);
endmodule

// File: rtl/kbd_event_track.sv
module kbd_event_track
  import kbd_rx_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  frame_result_t result_i,
  output logic [7:0]    code_o,
  output logic          release_o,
  output logic          valid_o,
  output logic          err_o
);
  logic       brk_q, brk_d;
  logic [7:0] code_q, code_d;
  logic       rel_q, rel_d;
  logic       valid_q, valid_d;
  logic       err_q, err_d;

  always_comb begin
    brk_d   = brk_q;
    code_d  = code_q;
    rel_d   = rel_q;
    valid_d = 1'b0;
    err_d   = 1'b0;
    if (result_i.done) begin
      if (!result_i.ok) begin
        err_d = 1'b1;
        brk_d = 1'b0;
      end else if (result_i.data == BREAK_PREFIX) begin
        brk_d = 1'b1;
      end else begin
        valid_d = 1'b1;
        code_d  = result_i.data;
        rel_d   = brk_q;
        brk_d   = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_q   <= 1'b0;
      code_q  <= '0;
      rel_q   <= 1'b0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      brk_q   <= brk_d;
      code_q  <= code_d;
      rel_q   <= rel_d;
      valid_q <= valid_d;
      err_q   <= err_d;
    end
  end

  assign code_o    = code_q;
  assign release_o = rel_q;
  assign valid_o   = valid_q;
  assign err_o     = err_q;

  assert_no_prefix_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> code_o != BREAK_PREFIX);
  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_o && err_o));
  assert_valid_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  assert_err_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);
  assert_err_drops_prefix_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !brk_q);
  assert_hold_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |=> (valid_o || $stable(code_o)));
endmodule

// File: rtl/kbd_frame_rx.sv
module kbd_frame_rx
  import kbd_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int IDLE_LIMIT  = 200000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       kbd_clk_i,
  input  logic       kbd_data_i,
  output logic [7:0] key_code_o,
  output logic       key_release_o,
  output logic       key_valid_o,
  output logic       frame_err_o
);
  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic          kdat_s;
  logic          kclk_fall;
  frame_result_t frame_res;

  // Reset asserts at once and releases on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  kbd_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .kclk_async_i (kbd_clk_i),
    .kdat_async_i (kbd_data_i),
    .kdat_o       (kdat_s),
    .kclk_fall_o  (kclk_fall)
  );

  kbd_frame_fsm #(.IDLE_LIMIT(IDLE_LIMIT)) fsm_i (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .kdat_i      (kdat_s),
    .kclk_fall_i (kclk_fall),
    .result_o    (frame_res)
  );

  kbd_event_track track_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .result_i  (frame_res),
    .code_o    (key_code_o),
    .release_o (key_release_o),
    .valid_o   (key_valid_o),
    .err_o     (frame_err_o)
  );
endmodule

// File: tb/kbd_frame_rx_tb.sv
module kbd_frame_rx_tb_top;
  localparam int HALF   = 10;
  localparam int LIMIT  = 100;
  localparam int WDOG   = 195000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       kbd_clk = 1'b1;
  logic       kbd_data = 1'b1;
  logic [7:0] key_code;
  logic       key_rel, key_valid, frame_err;

  int total = 0;
  int bad = 0;
  int n_valid = 0;
  int n_err = 0;
  int n_wide = 0;
  logic [7:0] seen_code = 8'h00;
  logic       seen_rel = 1'b0;
  logic       prev_valid = 1'b0;
  logic       prev_err = 1'b0;
  bit         finished = 1'b0;

  always #5 clk = ~clk;

  kbd_frame_rx #(.SYNC_STAGES(2), .IDLE_LIMIT(LIMIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .kbd_clk_i(kbd_clk), .kbd_data_i(kbd_data),
    .key_code_o(key_code), .key_release_o(key_rel),
    .key_valid_o(key_valid), .frame_err_o(frame_err)
  );

  // Pulse monitor, sampled away from the active edge.
  always @(negedge clk) begin
    if (key_valid) begin
      n_valid++;
      seen_code = key_code;
      seen_rel = key_rel;
    end
    if (frame_err) n_err++;
    if ((key_valid && frame_err) || (key_valid && prev_valid) || (frame_err && prev_err))
      n_wide++;
    prev_valid = key_valid;
    prev_err = frame_err;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [10:0] mk(input logic [7:0] b, input bit flip_par,
                                     input bit bad_start, input bit bad_stop);
    logic par;
    par = ~(^b) ^ flip_par;
    return {~bad_stop, par, b, bad_start};
  endfunction

  task automatic send_bits(input logic [10:0] bits, input int n);
    for (int i = 0; i < n; i++) begin
      kbd_data = bits[i];
      repeat (HALF) @(negedge clk);
      kbd_clk = 1'b0;
      repeat (HALF) @(negedge clk);
      kbd_clk = 1'b1;
    end
    repeat (HALF) @(negedge clk);
    kbd_data = 1'b1;
  endtask

  // Send one frame and check pulse counts and the reported event.
  task automatic frame_chk(input string req, input logic [10:0] bits,
                           input int exp_v, input int exp_e,
                           input logic [7:0] exp_code, input logic exp_rel);
    int v0, e0;
    v0 = n_valid;
    e0 = n_err;
    send_bits(bits, 11);
    repeat (30) @(negedge clk);
    check({req, " valid pulses"}, n_valid - v0, exp_v);
    check({req, " err pulses"}, n_err - e0, exp_e);
    check({req, " code"}, int'(key_code), int'(exp_code));
    check({req, " release"}, int'(key_rel), int'(exp_rel));
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=done", WDOG);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] last;
    repeat (4) @(negedge clk);
    check("R1 valid", int'(key_valid), 0);
    check("R1 err", int'(frame_err), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R1 code", int'(key_code), 0);
    check("R1 release", int'(key_rel), 0);

    // R2 R3: every byte value as a press.
    for (int b = 0; b < 256; b++) begin
      if (b != 8'hF0) frame_chk("R2 R3 press", mk(8'(b), 0, 0, 0), 1, 0, 8'(b), 1'b0);
    end
    last = 8'hFF;

    // R4 R10: release sweep, prefix alone keeps code and flag.
    for (int b = 3; b < 256; b += 8) begin
      frame_chk("R4 R10 prefix", mk(8'hF0, 0, 0, 0), 0, 0, last, 1'b0);
      frame_chk("R4 release", mk(8'(b), 0, 0, 0), 1, 0, 8'(b), 1'b1);
      frame_chk("R4 flag cleared", mk(8'(b), 0, 0, 0), 1, 0, 8'(b), 1'b0);
      last = 8'(b);
    end

    // R5 parity fault; R6 start and stop faults; R10 code held.
    frame_chk("R5 parity", mk(8'h1C, 1, 0, 0), 0, 1, last, 1'b0);
    frame_chk("R5 parity zero", mk(8'h00, 1, 0, 0), 0, 1, last, 1'b0);
    frame_chk("R6 start", mk(8'h32, 0, 1, 0), 0, 1, last, 1'b0);
    frame_chk("R6 stop", mk(8'h32, 0, 0, 1), 0, 1, last, 1'b0);

    // R7: fault drops a pending prefix.
    frame_chk("R7 prefix", mk(8'hF0, 0, 0, 0), 0, 0, last, 1'b0);
    frame_chk("R7 fault", mk(8'h4B, 1, 0, 0), 0, 1, last, 1'b0);
    frame_chk("R7 after fault", mk(8'h4B, 0, 0, 0), 1, 0, 8'h4B, 1'b0);
    frame_chk("R7 prefix stop", mk(8'hF0, 0, 0, 0), 0, 0, 8'h4B, 1'b0);
    frame_chk("R7 fault stop", mk(8'h29, 0, 0, 1), 0, 1, 8'h4B, 1'b0);
    frame_chk("R7 after stop fault", mk(8'h29, 0, 0, 0), 1, 0, 8'h29, 1'b0);

    // R8: fragment, idle past the limit, then a full frame.
    begin
      int v0, e0;
      v0 = n_valid;
      e0 = n_err;
      send_bits(mk(8'h5A, 0, 0, 0), 4);
      repeat (LIMIT + 60) @(negedge clk);
      check("R8 fragment silent valid", n_valid - v0, 0);
      check("R8 fragment silent err", n_err - e0, 0);
    end
    frame_chk("R8 realign", mk(8'h1C, 0, 0, 0), 1, 0, 8'h1C, 1'b0);
    frame_chk("R8 realign release pre", mk(8'hF0, 0, 0, 0), 0, 0, 8'h1C, 1'b0);
    send_bits(mk(8'h66, 0, 0, 0), 7);
    repeat (LIMIT + 60) @(negedge clk);
    frame_chk("R8 realign release", mk(8'h66, 0, 0, 0), 1, 0, 8'h66, 1'b1);

    check("R9 pulse shape", n_wide, 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule